// File: doc/BRIEF.md
# Time-of-Day Counter with Interval Wake Alarm

This block keeps time of day in four cascaded registers (tick fraction, seconds, minutes, hours) that advance from a fixed-rate tick pulse while the run input is high. A host loads the time through a small write port, and only while the counter is stopped. The time registers survive a synchronous reset when the counter is running. This lets a chip-level reset that leaves the clock domain alive keep the time intact.

Next to the clock sits an interval alarm. An 8-bit counter counts events of one chosen time unit and compares the count against a programmed interval. When the two meet, a sticky wake flag is raised and the counter starts again, so the flag recurs at a fixed period. The flag is meant to drive a wake-up or interrupt request. It stays set until the host clears it.

Top module: `rtc_wakeup_timer`

## Requirements
- R1: While `run` is high, each `tick` pulse advances `frac` by one. From TICK_HZ-1 (127 by default) it wraps to 0 and carries one into `sec` in the same cycle.
- R2: `sec` and `min` count 0 to 59. A carry into either register while it holds 59 or more sets it to 0 and passes a carry to the next register.
- R3: `hour` counts 0 to 23. A carry into `hour` while it holds 23 or more sets it to 0.
- R4: While `run` is low, `tick` has no effect on any time register.
- R5: A host write (`wr_en` high) selects a register with `wr_addr`: 0 `frac`, 1 `sec`, 2 `min`, 3 `hour`, 4 interval. A write to address 0 to 3 loads `wr_data` only while `run` is low. While `run` is high the write is dropped, and a `tick` in the same cycle still advances the time. Addresses 5 to 7 change nothing.
- R6: When `rst` is sampled high, all four time registers clear to 0 if `run` is low and keep their values if `run` is high. `tick` is ignored during reset.
- R7: `alarm_unit` selects the event the interval counter counts: 0 a tick, 1 a `sec` increment, 2 a `min` increment, 3 an `hour` increment. On the event that brings the count to the interval value, `wake_flag` is set in that cycle's edge and the count returns to 0, so the flag recurs every interval events. An interval of 0 means 256 events.
- R8: `wake_flag` stays set until `flag_clr` is sampled high. If a match and `flag_clr` fall in the same cycle, the flag is set.
- R9: While `alarm_en` is low, the interval count is held at 0 and `wake_flag` is not set. A write to address 4 loads the interval and restarts the count from 0.
- R10: Reset clears `wake_flag`, the interval register and the interval count, whatever the level of `run`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Counter enable level |
| tick | input | 1 | One-cycle pulse at TICK_HZ |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Host register select |
| wr_data | input | 8 | Host write data |
| alarm_en | input | 1 | Interval alarm enable |
| alarm_unit | input | 2 | Interval unit select |
| flag_clr | input | 1 | Clears the wake flag |
| frac | output | 8 | Tick fraction of a second |
| sec | output | 8 | Seconds |
| min | output | 8 | Minutes |
| hour | output | 8 | Hours |
| wake_flag | output | 1 | Sticky interval match flag |

## Verification
The bench drives a full-day rollover from 23:59:59 plus the last tick. A broken carry chain would show up there as a stale upper register or a premature zero. It puts a write and a tick in the same running cycle, where a design that lets the write through would lose the tick or load the value. It pulses reset once with `run` high and once with `run` low; a block that always cleared, or never cleared, fails one of the two. On the alarm side, the bench checks a repeated period, a clear that coincides with a match, a disabled alarm, a restart on an interval write, each unit select, and the interval value 0, which must mean 256 events rather than an immediate or a missing match.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [1:0] {
    UNIT_TICK = 2'd0,
    UNIT_SEC  = 2'd1,
    UNIT_MIN  = 2'd2,
    UNIT_HOUR = 2'd3
  } alarm_unit_e;

  localparam int NUM_STAGES = 4;

  function automatic int stage_limit(input int idx, input int tick_hz);
    case (idx)
      0:       return tick_hz;
      1:       return 60;
      2:       return 60;
      default: return 24;
    endcase
  endfunction
endpackage

// File: rtl/rtc_digit.sv
module rtc_digit #(
  parameter int DW    = 8,
  parameter int LIMIT = 60
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          inc,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam logic [DW-1:0] LAST = DW'(LIMIT - 1);
  localparam logic [DW-1:0] ONE  = DW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      if (!run) q <= '0;
    end else if (wr && !run) begin
      q <= wdata;
    end else if (inc) begin
      q <= (q >= LAST) ? '0 : q + ONE;
    end
  end

  AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
    (inc && !wr && q < LAST) |=> (q == $past(q) + ONE)); // R1
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (inc && !wr && q >= LAST) |=> (q == '0)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!run && !wr) |=> $stable(q)); // R4
  AST_RUN_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    (run && !inc) |=> $stable(q)); // R5
endmodule

// File: rtl/rtc_interval.sv
module rtc_interval #(
  parameter int CW = 8,
  parameter int NU = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NU-1:0] unit_ev,
  input  logic [1:0]    unit_sel,
  input  logic          alarm_en,
  input  logic          ival_wr,
  input  logic [CW-1:0] ival_data,
  input  logic          flag_clr,
  output logic          flag
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] ival;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nxt;
  logic          ev_sel;
  logic          hit;

  assign ev_sel  = unit_ev[unit_sel];
  assign cnt_nxt = cnt + ONE;
  assign hit     = alarm_en && !ival_wr && ev_sel && (cnt_nxt == ival);

  always_ff @(posedge clk) begin
    if (rst) begin
      ival <= '0;
      cnt  <= '0;
    end else if (ival_wr) begin
      ival <= ival_data;
      cnt  <= '0;
    end else if (!alarm_en) begin
      cnt <= '0;
    end else if (ev_sel) begin
      cnt <= hit ? '0 : cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           flag <= 1'b0;
    else if (hit)      flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag && !flag_clr) |=> flag); // R8
  AST_OFF_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
    (!alarm_en && !flag) |=> !flag); // R9
  AST_MATCH_RESTART: assert property (@(posedge clk) disable iff (rst)
    (alarm_en && !ival_wr && ev_sel && cnt_nxt == ival) |=> (flag && cnt == '0)); // R7
  AST_WR_RESTART: assert property (@(posedge clk) disable iff (rst)
    ival_wr |=> (cnt == '0)); // R9
endmodule

// File: rtl/rtc_wakeup_timer.sv
module rtc_wakeup_timer #(
  parameter int TICK_HZ = 128,
  parameter int DW      = 8,
  parameter int AW      = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          alarm_en,
  input  logic [1:0]    alarm_unit,
  input  logic          flag_clr,
  output logic [DW-1:0] frac,
  output logic [DW-1:0] sec,
  output logic [DW-1:0] min,
  output logic [DW-1:0] hour,
  output logic          wake_flag
);
  import rtc_pkg::*;

  localparam int            NS        = NUM_STAGES;
  localparam logic [AW-1:0] ADDR_IVAL = AW'(NS);

  logic [NS:0]   carry;
  logic [DW-1:0] val [NS];

  assign carry[0] = tick && run;

  for (genvar i = 0; i < NS; i++) begin : g_stage
    localparam int            LIM  = stage_limit(i, TICK_HZ);
    localparam logic [DW-1:0] LAST = DW'(LIM - 1);
    logic sel;
    assign sel = wr_en && (wr_addr == AW'(i));

    rtc_digit #(.DW(DW), .LIMIT(LIM)) u_digit (
      .clk   (clk),
      .rst   (rst),
      .run   (run),
      .inc   (carry[i]),
      .wr    (sel),
      .wdata (wr_data),
      .q     (val[i])
    );

    assign carry[i+1] = carry[i] && (val[i] >= LAST);
  end

  rtc_interval #(.CW(DW), .NU(NS)) u_interval (
    .clk       (clk),
    .rst       (rst),
    .unit_ev   (carry[NS-1:0]),
    .unit_sel  (alarm_unit),
    .alarm_en  (alarm_en),
    .ival_wr   (wr_en && (wr_addr == ADDR_IVAL)),
    .ival_data (wr_data),
    .flag_clr  (flag_clr),
    .flag      (wake_flag)
  );

  assign frac = val[0];
  assign sec  = val[1];
  assign min  = val[2];
  assign hour = val[3];
endmodule

// File: tb/rtc_wakeup_timer_tb.sv
module rtc_wakeup_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst, run, tick, wr_en, alarm_en, flag_clr;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic [1:0] alarm_unit;
  logic [7:0] frac, sec, min, hour;
  logic       wake_flag;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_wakeup_timer u_dut (
    .clk(clk), .rst(rst), .run(run), .tick(tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .alarm_en(alarm_en),
    .alarm_unit(alarm_unit), .flag_clr(flag_clr), .frac(frac), .sec(sec),
    .min(min), .hour(hour), .wake_flag(wake_flag)
  );

  typedef struct packed {
    logic [3:0] req;
    logic       run;
    logic       tick;
    logic       wr;
    logic [2:0] addr;
    logic [7:0] data;
    logic [7:0] f, s, m, h;
  } vec_t;

  // R5 loads, R4 idle tick, R3 day rollover, R5 dropped writes, R1 carry
  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{4'd5, 1'b0, 1'b0, 1'b1, 3'd0, 8'd5,   8'd5,   8'd0,  8'd0,  8'd0},
    '{4'd5, 1'b0, 1'b0, 1'b1, 3'd1, 8'd59,  8'd5,   8'd59, 8'd0,  8'd0},
    '{4'd5, 1'b0, 1'b0, 1'b1, 3'd2, 8'd59,  8'd5,   8'd59, 8'd59, 8'd0},
    '{4'd5, 1'b0, 1'b0, 1'b1, 3'd3, 8'd23,  8'd5,   8'd59, 8'd59, 8'd23},
    '{4'd4, 1'b0, 1'b1, 1'b0, 3'd0, 8'd0,   8'd5,   8'd59, 8'd59, 8'd23},
    '{4'd5, 1'b0, 1'b0, 1'b1, 3'd0, 8'd127, 8'd127, 8'd59, 8'd59, 8'd23},
    '{4'd3, 1'b1, 1'b1, 1'b0, 3'd0, 8'd0,   8'd0,   8'd0,  8'd0,  8'd0},
    '{4'd1, 1'b1, 1'b1, 1'b0, 3'd0, 8'd0,   8'd1,   8'd0,  8'd0,  8'd0},
    '{4'd5, 1'b1, 1'b1, 1'b1, 3'd1, 8'd7,   8'd2,   8'd0,  8'd0,  8'd0},
    '{4'd5, 1'b1, 1'b0, 1'b1, 3'd0, 8'd50,  8'd2,   8'd0,  8'd0,  8'd0},
    '{4'd5, 1'b0, 1'b0, 1'b1, 3'd5, 8'd9,   8'd2,   8'd0,  8'd0,  8'd0},
    '{4'd5, 1'b0, 1'b0, 1'b1, 3'd0, 8'd126, 8'd126, 8'd0,  8'd0,  8'd0},
    '{4'd1, 1'b1, 1'b1, 1'b0, 3'd0, 8'd0,   8'd127, 8'd0,  8'd0,  8'd0},
    '{4'd1, 1'b1, 1'b1, 1'b0, 3'd0, 8'd0,   8'd0,   8'd1,  8'd0,  8'd0}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_time(input string req, input int f, input int s, input int m, input int h);
    chk(req, "frac", frac, f);
    chk(req, "sec",  sec,  s);
    chk(req, "min",  min,  m);
    chk(req, "hour", hour, h);
  endtask

  // one clock: inputs applied at the negedge, outputs sampled at the next negedge
  task automatic step(input logic tk, input logic wr, input logic [2:0] a,
                      input logic [7:0] d, input logic clr);
    tick = tk; wr_en = wr; wr_addr = a; wr_data = d; flag_clr = clr;
    @(posedge clk);
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0; flag_clr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) step(1'b1, 1'b0, 3'd0, 8'd0, 1'b0);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    step(1'b0, 1'b1, a, d, 1'b0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; run = 1'b0; tick = 1'b0; wr_en = 1'b0; wr_addr = '0;
    wr_data = '0; alarm_en = 1'b0; alarm_unit = 2'd0; flag_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R6 / R10: reset state with run low
    chk_time("R6", 0, 0, 0, 0);
    chk("R10", "wake_flag", wake_flag, 0);

    for (int i = 0; i < NV; i++) begin
      run = VEC[i].run;
      step(VEC[i].tick, VEC[i].wr, VEC[i].addr, VEC[i].data, 1'b0);
      chk($sformatf("R%0d", VEC[i].req), "frac", frac, VEC[i].f);
      chk($sformatf("R%0d", VEC[i].req), "sec",  sec,  VEC[i].s);
      chk($sformatf("R%0d", VEC[i].req), "min",  min,  VEC[i].m);
      chk($sformatf("R%0d", VEC[i].req), "hour", hour, VEC[i].h);
    end

    // R6: reset while running keeps time, tick ignored
    run = 1'b1; rst = 1'b1;
    step(1'b1, 1'b0, 3'd0, 8'd0, 1'b0);
    rst = 1'b0;
    chk_time("R6", 0, 1, 0, 0);
    run = 1'b0; rst = 1'b1;
    step(1'b0, 1'b0, 3'd0, 8'd0, 1'b0);
    rst = 1'b0;
    chk_time("R6", 0, 0, 0, 0);

    // R7: tick unit, interval 3, periodic
    run = 1'b1; alarm_en = 1'b1; alarm_unit = 2'd0;
    step(1'b0, 1'b1, 3'd4, 8'd3, 1'b1);
    ticks(2);
    chk("R7", "flag before match", wake_flag, 0);
    ticks(1);
    chk("R7", "flag at match", wake_flag, 1);
    // R8: sticky
    ticks(2);
    chk("R8", "flag held", wake_flag, 1);
    step(1'b0, 1'b0, 3'd0, 8'd0, 1'b1);
    chk("R8", "flag cleared", wake_flag, 0);
    step(1'b1, 1'b0, 3'd0, 8'd0, 1'b1);
    chk("R8", "set beats clear", wake_flag, 1);
    step(1'b0, 1'b0, 3'd0, 8'd0, 1'b1);

    // R9: disabled alarm never sets the flag, count held at zero
    alarm_en = 1'b0;
    ticks(5);
    chk("R9", "flag while disabled", wake_flag, 0);
    alarm_en = 1'b1;
    ticks(2);
    chk("R9", "count restarted", wake_flag, 0);
    ticks(1);
    chk("R9", "match after enable", wake_flag, 1);
    step(1'b0, 1'b0, 3'd0, 8'd0, 1'b1);
    // R9: interval write restarts count
    ticks(2);
    wr(3'd4, 8'd3);
    ticks(2);
    chk("R9", "no early match after rewrite", wake_flag, 0);
    ticks(1);
    chk("R9", "match after rewrite", wake_flag, 1);
    step(1'b0, 1'b0, 3'd0, 8'd0, 1'b1);

    // R7: seconds unit, interval 2
    run = 1'b0;
    wr(3'd0, 8'd127); wr(3'd1, 8'd0); wr(3'd2, 8'd0); wr(3'd3, 8'd0);
    alarm_unit = 2'd1;
    step(1'b0, 1'b1, 3'd4, 8'd2, 1'b1);
    run = 1'b1;
    ticks(1);
    chk("R7", "sec unit first", wake_flag, 0);
    ticks(5);
    chk("R7", "tick not a second", wake_flag, 0);
    run = 1'b0;
    wr(3'd0, 8'd127);
    run = 1'b1;
    ticks(1);
    chk("R2", "sec", sec, 2);
    chk("R7", "sec unit match", wake_flag, 1);
    step(1'b0, 1'b0, 3'd0, 8'd0, 1'b1);

    // R7 / R2: hour unit, interval 1
    run = 1'b0;
    wr(3'd0, 8'd127); wr(3'd1, 8'd59); wr(3'd2, 8'd59); wr(3'd3, 8'd5);
    alarm_unit = 2'd3;
    wr(3'd4, 8'd1);
    run = 1'b1;
    ticks(1);
    chk_time("R2", 0, 0, 0, 6);
    chk("R7", "hour unit match", wake_flag, 1);
    step(1'b0, 1'b0, 3'd0, 8'd0, 1'b1);

    // R7: interval 0 means 256 events
    alarm_unit = 2'd0;
    step(1'b0, 1'b1, 3'd4, 8'd0, 1'b1);
    ticks(255);
    chk("R7", "zero interval before 256", wake_flag, 0);
    ticks(1);
    chk("R7", "zero interval at 256", wake_flag, 1);

    // R10: reset while running clears the flag
    rst = 1'b1;
    step(1'b0, 1'b0, 3'd0, 8'd0, 1'b0);
    rst = 1'b0;
    chk("R10", "flag after reset", wake_flag, 0);

    finish_run();
  end
endmodule